// File: doc/BRIEF.md
# Accumulator Execute Stage with Result Routing

This block is the byte-wide execute stage of an accumulator-style microcontroller. It keeps the working register W and, for each issued operation, combines W with a byte read from data memory. The supported operations are move, add, add-with-carry and decrement. A single destination bit sent with each operation decides where the result goes. It is written either into W or out through a registered file-write port, so the addressed memory byte can be updated.

Carry, zero and negative flags are kept beside W. Add-with-carry feeds the stored carry back in as its incoming carry. Wider numbers can therefore be added one byte at a time, with the carry passed between bytes. The stage does not fetch or decode instructions and does not form memory addresses. It receives an already-decoded 2-bit operation code and the operand that was read.

Top module: `accum_alu`

## Requirements
- R1: After synchronous reset, W is 0x00, the carry, zero and negative flags are 0, file write-enable is 0 and file write-data is 0x00.
- R2: When an operation is issued with the destination bit at 0, its result is loaded into W on the next clock edge, and file write-enable stays low.
- R3: When an operation is issued with the destination bit at 1, file write-enable is high for exactly the one cycle after the issuing edge, file write-data carries the result, and W keeps its value.
- R4: Operation code 0 (move) produces the file operand unchanged as the result, and the carry flag keeps its previous value.
- R5: Operation code 1 (add) produces the low 8 bits of W plus the operand, and sets carry to the ninth bit of the sum.
- R6: Operation code 2 (add-with-carry) produces W plus the operand plus the current carry flag, and sets carry to the ninth bit of that sum.
- R7: Operation code 3 (decrement) produces the operand minus one, modulo 256, and sets carry to 1 exactly when the operand was non-zero (no borrow).
- R8: After every issued operation, the zero flag is 1 exactly when the 8-bit result is 0x00.
- R9: After every issued operation, the negative flag equals bit 7 of the result.
- R10: In a cycle with no operation issued (valid low), W and all flags keep their values and file write-enable is low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | An operation is issued this cycle |
| op_code | input | 2 | 0 move, 1 add, 2 add-with-carry, 3 decrement |
| op_dest | input | 1 | 0 result to W, 1 result to memory |
| file_rdata | input | 8 | Operand byte read from data memory |
| file_wdata | output | 8 | Result byte to be written to memory |
| file_we | output | 1 | Memory write strobe, one cycle wide |
| w_out | output | 8 | Current W register value |
| flag_c | output | 1 | Carry flag (no-borrow on decrement) |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |

## Verification
All results of an operation appear one cycle after the clock edge that samples it. The new W value, the three flags, the write strobe and the write data are all registered at that single edge. The bench drives inputs on the falling edge and steps a behavioural model at each rising edge. It compares every output shortly after that edge, so the comparison always lands in the cycle where the result first becomes visible. A write strobe must therefore be seen in that cycle and be gone one cycle later. Multi-byte add chains and decrements of 0x00 and 0x01 exercise the carry and zero corners.

// File: rtl/accum_alu_pkg.sv
package accum_alu_pkg;

    localparam int DATA_W = 8;
    localparam int OP_W   = 2;

    typedef enum logic [OP_W-1:0] {
        OP_MOVE = 2'd0,
        OP_ADD  = 2'd1,
        OP_ADDC = 2'd2,
        OP_DEC  = 2'd3
    } alu_op_e;

    typedef enum logic {
        DST_W    = 1'b0,
        DST_FILE = 1'b1
    } alu_dst_e;

    typedef struct packed {
        logic [DATA_W-1:0] value;
        logic              carry;
        logic              carry_upd;
    } alu_res_t;

    typedef struct packed {
        logic c;
        logic z;
        logic n;
    } alu_flags_t;

    function automatic logic [DATA_W:0] sum_with_cin(
        input logic [DATA_W-1:0] a,
        input logic [DATA_W-1:0] b,
        input logic              cin
    );
        return {1'b0, a} + {1'b0, b} + {{DATA_W{1'b0}}, cin};
    endfunction

    function automatic logic is_zero(input logic [DATA_W-1:0] v);
        return (v == '0);
    endfunction

endpackage

// File: rtl/accum_alu_core.sv
module accum_alu_core
    import accum_alu_pkg::*;
(
    input  alu_op_e           op,
    input  logic [DATA_W-1:0] w_val,
    input  logic [DATA_W-1:0] f_val,
    input  logic              c_in,
    output alu_res_t          res
);

    logic [DATA_W:0] wide_sum;

    always_comb begin
        wide_sum      = sum_with_cin(w_val, f_val, (op == OP_ADDC) ? c_in : 1'b0);
        res.value     = f_val;
        res.carry     = c_in;
        res.carry_upd = 1'b0;
        unique case (op)
            OP_MOVE: begin
                res.value     = f_val;
                res.carry     = c_in;
                res.carry_upd = 1'b0;
            end
            OP_ADD, OP_ADDC: begin
                res.value     = wide_sum[DATA_W-1:0];
                res.carry     = wide_sum[DATA_W];
                res.carry_upd = 1'b1;
            end
            OP_DEC: begin
                res.value     = f_val - {{(DATA_W-1){1'b0}}, 1'b1};
                res.carry     = ~is_zero(f_val);
                res.carry_upd = 1'b1;
            end
            default: begin
                res.value     = f_val;
                res.carry     = c_in;
                res.carry_upd = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/accum_alu_flags.sv
module accum_alu_flags
    import accum_alu_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       upd,
    input  alu_res_t   res,
    output alu_flags_t flags
);

    alu_flags_t flags_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_q <= '0;
        end else if (upd) begin
            flags_q.z <= is_zero(res.value);
            flags_q.n <= res.value[DATA_W-1];
            if (res.carry_upd) begin
                flags_q.c <= res.carry;
            end
        end
    end

    assign flags = flags_q;

endmodule

// File: rtl/accum_alu_route.sv
module accum_alu_route
    import accum_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  alu_dst_e          dst,
    input  logic [DATA_W-1:0] result,
    output logic [DATA_W-1:0] w_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              we_q
);

    logic to_w;
    logic to_file;

    always_comb begin
        to_w    = upd && (dst == DST_W);
        to_file = upd && (dst == DST_FILE);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            w_q     <= '0;
            wdata_q <= '0;
            we_q    <= 1'b0;
        end else begin
            we_q <= to_file;
            if (to_w) begin
                w_q <= result;
            end
            if (to_file) begin
                wdata_q <= result;
            end
        end
    end

endmodule

// File: rtl/accum_alu.sv
module accum_alu
    import accum_alu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [OP_W-1:0]   op_code,
    input  logic              op_dest,
    input  logic [DATA_W-1:0] file_rdata,
    output logic [DATA_W-1:0] file_wdata,
    output logic              file_we,
    output logic [DATA_W-1:0] w_out,
    output logic              flag_c,
    output logic              flag_z,
    output logic              flag_n
);

    alu_op_e           op_e;
    alu_dst_e          dst_e;
    alu_res_t          res;
    alu_flags_t        flags;
    logic [DATA_W-1:0] w_q;

    assign op_e  = alu_op_e'(op_code);
    assign dst_e = alu_dst_e'(op_dest);

    accum_alu_core u_core (
        .op    (op_e),
        .w_val (w_q),
        .f_val (file_rdata),
        .c_in  (flags.c),
        .res   (res)
    );

    accum_alu_flags u_flags (
        .clk   (clk),
        .rst   (rst),
        .upd   (op_valid),
        .res   (res),
        .flags (flags)
    );

    accum_alu_route u_route (
        .clk     (clk),
        .rst     (rst),
        .upd     (op_valid),
        .dst     (dst_e),
        .result  (res.value),
        .w_q     (w_q),
        .wdata_q (file_wdata),
        .we_q    (file_we)
    );

    assign w_out  = w_q;
    assign flag_c = flags.c;
    assign flag_z = flags.z;
    assign flag_n = flags.n;

endmodule

// File: rtl/accum_alu_chk.sv
module accum_alu_chk (
    input logic       clk,
    input logic       rst,
    input logic       op_valid,
    input logic [1:0] op_code,
    input logic       op_dest,
    input logic [7:0] file_rdata,
    input logic [7:0] file_wdata,
    input logic       file_we,
    input logic [7:0] w_out,
    input logic       flag_c,
    input logic       flag_z,
    input logic       flag_n
);

    logic [7:0] shown_res;
    assign shown_res = file_we ? file_wdata : w_out;

    assert_w_dest_no_strobe_R2: assert property (@(posedge clk) disable iff (rst)
        (op_valid && !op_dest) |=> !file_we);

    assert_file_strobe_R3: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_dest) |=> (file_we && $stable(w_out)));

    assert_move_keeps_carry_R4: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0) |=> $stable(flag_c));

    assert_dec_to_w_R7: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd3 && !op_dest) |=>
            (w_out == 8'($past(file_rdata) - 8'd1)));

    assert_zero_flag_R8: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (flag_z == (shown_res == 8'h00)));

    assert_neg_flag_R9: assert property (@(posedge clk) disable iff (rst)
        op_valid |=> (flag_n == shown_res[7]));

    assert_idle_hold_R10: assert property (@(posedge clk) disable iff (rst)
        !op_valid |=> (!file_we && $stable(w_out) && $stable(flag_c)
                       && $stable(flag_z) && $stable(flag_n)));

endmodule

bind accum_alu accum_alu_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .op_valid   (op_valid),
    .op_code    (op_code),
    .op_dest    (op_dest),
    .file_rdata (file_rdata),
    .file_wdata (file_wdata),
    .file_we    (file_we),
    .w_out      (w_out),
    .flag_c     (flag_c),
    .flag_z     (flag_z),
    .flag_n     (flag_n)
);

// File: tb/accum_alu_tb.sv
`timescale 1ns/1ps
module accum_alu_tb;

    logic       clk = 1'b0;
    logic       rst;
    logic       op_valid;
    logic [1:0] op_code;
    logic       op_dest;
    logic [7:0] file_rdata;
    logic [7:0] file_wdata;
    logic       file_we;
    logic [7:0] w_out;
    logic       flag_c, flag_z, flag_n;

    int n_tests = 0;
    int n_fail  = 0;

    int m_w, m_c, m_z, m_n, m_we, m_wd;

    always #2 clk = ~clk;

    accum_alu u_dut (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_dest(op_dest), .file_rdata(file_rdata), .file_wdata(file_wdata),
        .file_we(file_we), .w_out(w_out), .flag_c(flag_c), .flag_z(flag_z),
        .flag_n(flag_n)
    );

    task automatic check(string tag, string what, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check(tag, "w_out", int'(w_out), m_w);
        check(tag, "flag_c", int'(flag_c), m_c);
        check(tag, "flag_z", int'(flag_z), m_z);
        check(tag, "flag_n", int'(flag_n), m_n);
        check(tag, "file_we", int'(file_we), m_we);
        if (m_we != 0) check(tag, "file_wdata", int'(file_wdata), m_wd);
    endtask

    // behavioural model of one issued cycle
    task automatic model(int v, int op, int dst, int f);
        int r;
        m_we = 0;
        if (v == 0) return;
        r = 0;
        case (op)
            0: r = f;
            1: begin r = m_w + f;        m_c = (r > 255) ? 1 : 0; end
            2: begin r = m_w + f + m_c;  m_c = (r > 255) ? 1 : 0; end
            default: begin r = f - 1;    m_c = (f != 0) ? 1 : 0; end
        endcase
        r = r & 255;
        m_z = (r == 0) ? 1 : 0;
        m_n = (r >= 128) ? 1 : 0;
        if (dst == 1) begin m_we = 1; m_wd = r; end
        else m_w = r;
    endtask

    task automatic step(int v, int op, int dst, int f, string tag);
        @(negedge clk);
        op_valid   = v[0];
        op_code    = op[1:0];
        op_dest    = dst[0];
        file_rdata = f[7:0];
        @(posedge clk);
        model(v, op, dst, f);
        #1;
        compare_all(tag);
    endtask

    initial begin
        #(4 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual=expired expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 0; op_code = 0; op_dest = 0; file_rdata = 0;
        m_w = 0; m_c = 0; m_z = 0; m_n = 0; m_we = 0; m_wd = 0;
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        compare_all("R1");
        check("R1", "file_wdata", int'(file_wdata), 0);
        @(negedge clk); rst = 1'b0;

        step(1, 0, 0, 8'h80, "R4");          // move to W, N set
        step(1, 0, 0, 8'h00, "R8");          // move zero
        step(1, 0, 0, 8'hFF, "R2");
        step(1, 1, 1, 8'h01, "R5");          // FF+01 -> file 00, carry, Z
        step(0, 0, 0, 8'h00, "R3");          // strobe gone
        step(1, 0, 0, 8'h12, "R4");          // carry kept
        // multi-byte add 0x12F0 + 0x0120 : low then high with carry
        step(1, 0, 0, 8'hF0, "R2");
        step(1, 1, 1, 8'h20, "R5");
        step(1, 0, 0, 8'h12, "R2");
        step(1, 2, 1, 8'h01, "R6");
        step(1, 2, 0, 8'h7F, "R6");
        step(1, 3, 0, 8'h00, "R7");          // 0 - 1 -> FF, borrow
        step(1, 3, 0, 8'h01, "R7");          // -> 0, no borrow, Z
        step(1, 3, 1, 8'h81, "R7");
        step(1, 3, 1, 8'h01, "R3");
        step(1, 3, 1, 8'h05, "R3");          // back-to-back writes
        step(0, 1, 1, 8'h55, "R10");
        step(0, 3, 0, 8'h00, "R10");

        for (int i = 0; i < 400; i++) begin
            int v, op, dst, f;
            v   = ($urandom_range(0, 3) != 0) ? 1 : 0;
            op  = $urandom_range(0, 3);
            dst = $urandom_range(0, 1);
            f   = $urandom_range(0, 255);
            case (op)
                0: step(v, op, dst, f, "R4");
                1: step(v, op, dst, f, "R5");
                2: step(v, op, dst, f, "R6");
                default: step(v, op, dst, f, "R7");
            endcase
        end
        step(0, 0, 0, 0, "R9");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule